// File: doc/BRIEF.md
# End-Pointer Memory-to-Memory DMA Engine

This block is a single-channel transfer engine that copies a run of items from one memory region to another. Software describes a transfer with a three-word descriptor in a control table: the source end pointer, the destination end pointer and a control word. Each end pointer holds the address of the final item, inclusive. After software arms the channel through set/clear command strobes and issues a software request, the engine reads the descriptor, checks it and moves every item. It goes through a simple request/acknowledge memory port, one read followed by one write per item.

Each address is derived backward from its end pointer using the number of items still to move. In auto-request mode a single request runs the whole transfer. The engine still drops the memory port for one cycle after every 2^n items, where n is the arbitration code, so other masters can be served. At the end it writes the control word back with its count and mode fields cleared, turns off the channel enable and pulses a completion interrupt. A malformed descriptor is rejected with an error pulse and no item moves.

The state machine uses these states. IDLE waits for a qualified start. FETCH_SRC, FETCH_DST and FETCH_CTL read the three descriptor words. CHECK validates the control word. READ and WRITE move one item. ARB yields the port. WBACK writes the control word back. DONE and ERR each last one cycle. The transitions are as follows:
- IDLE goes to FETCH_SRC on a start.
- Each fetch state advances on acknowledge, and FETCH_CTL goes to CHECK.
- CHECK goes to READ if the descriptor is valid, otherwise to ERR.
- READ goes to WRITE on acknowledge.
- WRITE goes to WBACK after the last item, to ARB when an arbitration slot fills, and otherwise back to READ.
- ARB goes to READ.
- WBACK goes to DONE on acknowledge.
- DONE and ERR go to IDLE.

Top module: `endptr_dma`

## Requirements
- R1: After reset `ch_en`=0, `ch_mask`=1, `ch_burst`=0, `busy`=0 and `mem_req`=0.
- R2: A `cfg_wr` strobe acts on `cfg_sel`: 0 sets enable, 1 clears enable, 2 sets mask, 3 clears mask, 4 is a software request, 5 sets burst-only, 6 clears burst-only.
- R3: A software request starts a transfer only when enable=1, mask=0, burst-only=0 and the engine is idle. Any other request is dropped and is not held pending.
- R4: The descriptor is read as three words from the table base: source end pointer at +0, destination end pointer at +4 and control word at +8. The control word fields are destination increment [31:30], destination size [29:28], source increment [27:26], source size [25:24], arbitration code [17:14], count-minus-one [13:4] and mode [2:0].
- R5: The number of items moved is the count-minus-one field plus one, from 1 to 1024.
- R6: With k items still to move, the address is the end pointer minus (k-1) shifted left by the increment code (0, 1 and 2 give steps of 1, 2 and 4 bytes). Increment code 3 holds the address at the end pointer.
- R7: Size codes 0, 1 and 2 move bytes, halfwords and words, and `mem_size` carries the code. Read data is masked to the item width.
- R8: With arbitration code n, `arb_yield` pulses once, with `mem_req` low, after each group of 2^n items when items remain. Codes of 10 and above never yield.
- R9: On completion the control word at base+8 is rewritten with count-minus-one and mode cleared to 0 and all other bits kept.
- R10: After the write-back `done_irq` is high for exactly one cycle and `ch_en` reads 0 from the next cycle.
- R11: A source or destination size of 3, unequal sizes, or a mode other than 2 gives a single-cycle `err_irq`. No item is written, there is no write-back, and enable is cleared.
- R12: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_base | input | AW | Control table base address, latched at start |
| cfg_wr | input | 1 | Command strobe |
| cfg_sel | input | 3 | Command select |
| ch_en | output | 1 | Channel enable state |
| ch_mask | output | 1 | Channel mask state |
| ch_burst | output | 1 | Burst-only state |
| busy | output | 1 | Engine not idle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Access complete |
| arb_yield | output | 1 | One-cycle port yield |
| done_irq | output | 1 | Completion pulse |
| err_irq | output | 1 | Descriptor error pulse |

## Verification
A wrong address step or a wrong remaining count shows up as destination bytes that differ from the expected image, or as writes outside the destination window, so it is seen once the transfer ends. An arbitration counter that is out of step changes the number of yield pulses. A bad descriptor decode shows up as an error pulse where none is due, or the reverse, within a few cycles of the third fetch. A stale enable, mask or burst-only bit makes a request start when it should not, or fail to start, and this is visible on `busy` in the cycle after the strobe.

// File: rtl/endptr_dma_pkg.sv
package endptr_dma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_SRC,
        S_FETCH_DST,
        S_FETCH_CTL,
        S_CHECK,
        S_READ,
        S_WRITE,
        S_ARB,
        S_WBACK,
        S_DONE,
        S_ERR
    } dma_state_e;

    typedef enum logic [2:0] {
        SEL_ENA_SET   = 3'd0,
        SEL_ENA_CLR   = 3'd1,
        SEL_MASK_SET  = 3'd2,
        SEL_MASK_CLR  = 3'd3,
        SEL_SWREQ     = 3'd4,
        SEL_BURST_SET = 3'd5,
        SEL_BURST_CLR = 3'd6
    } cfg_sel_e;

    localparam logic [2:0] MODE_STOP = 3'd0;
    localparam logic [2:0] MODE_AUTO = 3'd2;

    typedef struct packed {
        logic [1:0] dst_inc;
        logic [1:0] dst_size;
        logic [1:0] src_inc;
        logic [1:0] src_size;
        logic [5:0] rsvd;
        logic [3:0] arb_code;
        logic [9:0] count_m1;
        logic       nxt_burst;
        logic [2:0] mode;
    } ctl_word_t;

    function automatic ctl_word_t retire_ctl(ctl_word_t c);
        ctl_word_t r;
        r          = c;
        r.count_m1 = '0;
        r.mode     = MODE_STOP;
        return r;
    endfunction

    function automatic logic [31:0] width_mask(logic [1:0] sz);
        logic [31:0] m;
        unique case (sz)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    function automatic logic ctl_is_bad(ctl_word_t c);
        return (c.src_size == 2'd3) || (c.dst_size == 2'd3) ||
               (c.src_size != c.dst_size) || (c.mode != MODE_AUTO);
    endfunction

endpackage

// File: rtl/endptr_dma_regs.sv
module endptr_dma_regs
    import endptr_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_sel,
    input  logic       idle,
    input  logic       clr_en,
    output logic       en_q,
    output logic       mask_q,
    output logic       burst_q,
    output logic       start
);

    logic sel_hit [7];

    for (genvar g = 0; g < 7; g++) begin : g_dec
        assign sel_hit[g] = cfg_wr && (cfg_sel == 3'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mask_q  <= 1'b1;
            burst_q <= 1'b0;
        end else begin
            if (clr_en || sel_hit[SEL_ENA_CLR]) begin
                en_q <= 1'b0;
            end else if (sel_hit[SEL_ENA_SET]) begin
                en_q <= 1'b1;
            end
            if (sel_hit[SEL_MASK_SET]) begin
                mask_q <= 1'b1;
            end else if (sel_hit[SEL_MASK_CLR]) begin
                mask_q <= 1'b0;
            end
            if (sel_hit[SEL_BURST_SET]) begin
                burst_q <= 1'b1;
            end else if (sel_hit[SEL_BURST_CLR]) begin
                burst_q <= 1'b0;
            end
        end
    end

    assign start = sel_hit[SEL_SWREQ] && en_q && !mask_q && !burst_q && idle;

endmodule

// File: rtl/endptr_dma_addr.sv
module endptr_dma_addr #(
    parameter int AW    = 32,
    parameter int CNT_W = 11
) (
    input  logic [AW-1:0]    end_ptr,
    input  logic [CNT_W-1:0] remaining,
    input  logic [1:0]       inc,
    output logic [AW-1:0]    addr
);

    localparam int OFF_W = CNT_W + 2;

    logic [CNT_W-1:0] rem_m1;
    logic [OFF_W-1:0] off;

    always_comb begin
        rem_m1 = remaining - CNT_W'(1);
        if (inc == 2'd3) begin
            off = '0;
        end else begin
            off = {2'b00, rem_m1} << inc;
        end
        addr = end_ptr - {{(AW-OFF_W){1'b0}}, off};
    end

endmodule

// File: rtl/endptr_dma_arb.sv
module endptr_dma_arb #(
    parameter int CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       item_done,
    input  logic [3:0] arb_code,
    output logic       slot_full
);

    localparam int LOG_MAX = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot_len;

    always_comb begin
        if (32'(arb_code) >= LOG_MAX) begin
            slot_len = CNT_W'(1) << LOG_MAX;
        end else begin
            slot_len = CNT_W'(1) << arb_code;
        end
        slot_full = item_done && ((cnt_q + CNT_W'(1)) == slot_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || slot_full) begin
            cnt_q <= '0;
        end else if (item_done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/endptr_dma_fsm.sv
module endptr_dma_fsm
    import endptr_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    tbl_base,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    input  logic [AW-1:0]    src_addr,
    input  logic [AW-1:0]    dst_addr,
    input  logic             slot_full,
    output logic [AW-1:0]    src_end,
    output logic [AW-1:0]    dst_end,
    output logic [CNT_W-1:0] remaining,
    output logic [1:0]       src_inc,
    output logic [1:0]       dst_inc,
    output logic [3:0]       arb_code,
    output logic             arb_load,
    output logic             item_done,
    output logic             clr_en,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [1:0]       mem_size,
    output logic [31:0]      mem_wdata,
    output logic             arb_yield,
    output logic             done_irq,
    output logic             err_irq
);

    dma_state_e       state_q, state_d;
    ctl_word_t        ctl_q;
    logic [AW-1:0]    base_q;
    logic [31:0]      data_q;
    logic             last_item;

    assign last_item = (remaining == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_FETCH_SRC;
            S_FETCH_SRC: if (mem_ack) state_d = S_FETCH_DST;
            S_FETCH_DST: if (mem_ack) state_d = S_FETCH_CTL;
            S_FETCH_CTL: if (mem_ack) state_d = S_CHECK;
            S_CHECK:     state_d = ctl_is_bad(ctl_q) ? S_ERR : S_READ;
            S_READ:      if (mem_ack) state_d = S_WRITE;
            S_WRITE: begin
                if (mem_ack) begin
                    if (last_item) begin
                        state_d = S_WBACK;
                    end else if (slot_full) begin
                        state_d = S_ARB;
                    end else begin
                        state_d = S_READ;
                    end
                end
            end
            S_ARB:       state_d = S_READ;
            S_WBACK:     if (mem_ack) state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            S_ERR:       state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            src_end   <= '0;
            dst_end   <= '0;
            ctl_q     <= '0;
            remaining <= '0;
            data_q    <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                base_q <= tbl_base;
            end
            if (mem_ack) begin
                unique case (state_q)
                    S_FETCH_SRC: src_end <= mem_rdata[AW-1:0];
                    S_FETCH_DST: dst_end <= mem_rdata[AW-1:0];
                    S_FETCH_CTL: begin
                        ctl_q     <= ctl_word_t'(mem_rdata);
                        remaining <= CNT_W'(mem_rdata[13:4]) + CNT_W'(1);
                    end
                    S_READ:  data_q    <= mem_rdata & width_mask(ctl_q.src_size);
                    S_WRITE: remaining <= remaining - CNT_W'(1);
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = '0;
        arb_yield = 1'b0;
        done_irq  = 1'b0;
        err_irq   = 1'b0;
        clr_en    = 1'b0;
        arb_load  = 1'b0;
        item_done = 1'b0;
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_FETCH_SRC: begin
                mem_req  = 1'b1;
                mem_addr = base_q;
            end
            S_FETCH_DST: begin
                mem_req  = 1'b1;
                mem_addr = base_q + AW'(4);
            end
            S_FETCH_CTL: begin
                mem_req  = 1'b1;
                mem_addr = base_q + AW'(8);
            end
            S_CHECK: arb_load = 1'b1;
            S_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                mem_size = ctl_q.src_size;
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_size  = ctl_q.dst_size;
                mem_wdata = data_q;
                item_done = mem_ack;
            end
            S_ARB: arb_yield = 1'b1;
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = base_q + AW'(8);
                mem_wdata = retire_ctl(ctl_q);
            end
            S_DONE: begin
                done_irq = 1'b1;
                clr_en   = 1'b1;
            end
            S_ERR: begin
                err_irq = 1'b1;
                clr_en  = 1'b1;
            end
            default: ;
        endcase
    end

    assign src_inc  = ctl_q.src_inc;
    assign dst_inc  = ctl_q.dst_inc;
    assign arb_code = ctl_q.arb_code;

endmodule

// File: rtl/endptr_dma.sv
module endptr_dma
    import endptr_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] tbl_base,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_sel,
    output logic          ch_en,
    output logic          ch_mask,
    output logic          ch_burst,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          arb_yield,
    output logic          done_irq,
    output logic          err_irq
);

    logic             start, clr_en, slot_full, arb_load, item_done;
    logic [AW-1:0]    src_end, dst_end, src_addr, dst_addr;
    logic [CNT_W-1:0] remaining;
    logic [1:0]       src_inc, dst_inc;
    logic [3:0]       arb_code;

    endptr_dma_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_sel (cfg_sel),
        .idle    (!busy),
        .clr_en  (clr_en),
        .en_q    (ch_en),
        .mask_q  (ch_mask),
        .burst_q (ch_burst),
        .start   (start)
    );

    endptr_dma_addr #(.AW(AW), .CNT_W(CNT_W)) u_src_addr (
        .end_ptr   (src_end),
        .remaining (remaining),
        .inc       (src_inc),
        .addr      (src_addr)
    );

    endptr_dma_addr #(.AW(AW), .CNT_W(CNT_W)) u_dst_addr (
        .end_ptr   (dst_end),
        .remaining (remaining),
        .inc       (dst_inc),
        .addr      (dst_addr)
    );

    endptr_dma_arb #(.CNT_W(CNT_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (arb_load),
        .item_done (item_done),
        .arb_code  (arb_code),
        .slot_full (slot_full)
    );

    endptr_dma_fsm #(.AW(AW), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tbl_base  (tbl_base),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .slot_full (slot_full),
        .src_end   (src_end),
        .dst_end   (dst_end),
        .remaining (remaining),
        .src_inc   (src_inc),
        .dst_inc   (dst_inc),
        .arb_code  (arb_code),
        .arb_load  (arb_load),
        .item_done (item_done),
        .clr_en    (clr_en),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .arb_yield (arb_yield),
        .done_irq  (done_irq),
        .err_irq   (err_irq)
    );

endmodule

// File: rtl/endptr_dma_chk.sv
module endptr_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ch_en,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          arb_yield,
    input logic          done_irq,
    input logic          err_irq
);

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r8_yield_port_free: assert property (@(posedge clk) disable iff (!rst_n)
        arb_yield |-> !mem_req);

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    a_r10_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !ch_en);

    a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> (!err_irq && !ch_en));

    a_r11_err_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_irq && done_irq));

    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind endptr_dma endptr_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .arb_yield (arb_yield),
    .done_irq  (done_irq),
    .err_irq   (err_irq)
);

// File: tb/endptr_dma_bench.sv
module endptr_dma_bench;

    localparam int AW = 32;
    localparam logic [31:0] TBL = 32'h800;
    localparam logic [31:0] SRC = 32'h100;
    localparam logic [31:0] DST = 32'h400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] tbl_base = TBL;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic          ch_en, ch_mask, ch_burst, busy;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;
    logic          arb_yield, done_irq, err_irq;

    always #2 clk = ~clk;

    endptr_dma u_endptr_dma (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .ch_en(ch_en), .ch_mask(ch_mask), .ch_burst(ch_burst), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .arb_yield(arb_yield), .done_irq(done_irq),
        .err_irq(err_irq)
    );

    logic [7:0] mem  [4096];
    logic [7:0] expm [4096];

    int n_total = 0;
    int n_pass  = 0;
    int done_cnt = 0, err_cnt = 0, yield_cnt = 0, busy_cnt = 0;
    bit finished = 1'b0;

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++) begin
                    if (b < (1 << mem_size)) begin
                        mem[(mem_addr + 32'(b)) & 32'hFFF] = mem_wdata[8*b +: 8];
                    end
                end
            end else begin
                logic [31:0] rd;
                rd = '0;
                for (int b = 0; b < 4; b++) begin
                    if (b < (1 << mem_size)) begin
                        rd[8*b +: 8] = mem[(mem_addr + 32'(b)) & 32'hFFF];
                    end
                end
                mem_rdata <= rd;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_irq)  done_cnt++;
            if (err_irq)   err_cnt++;
            if (arb_yield) yield_cnt++;
            if (busy)      busy_cnt++;
        end
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    task automatic cmd(logic [2:0] sel);
        @(negedge clk);
        cfg_wr  = 1'b1;
        cfg_sel = sel;
        @(negedge clk);
        cfg_wr  = 1'b0;
    endtask

    function automatic logic [31:0] ctl_word(int dinc, int dsz, int sinc, int ssz,
                                             int arb, int n, int mode);
        return {2'(dinc), 2'(dsz), 2'(sinc), 2'(ssz), 6'd0, 4'(arb),
                10'(n - 1), 1'b0, 3'(mode)};
    endfunction

    task automatic put_word(logic [31:0] a, logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[(a + 32'(b)) & 32'hFFF] = v[8*b +: 8];
    endtask

    function automatic logic [31:0] get_word(logic [31:0] a);
        logic [31:0] v;
        for (int b = 0; b < 4; b++) v[8*b +: 8] = mem[(a + 32'(b)) & 32'hFFF];
        return v;
    endfunction

    // step in bytes for an increment code; 0 means fixed
    function automatic int step_of(int inc);
        return (inc == 3) ? 0 : (1 << inc);
    endfunction

    // Fill memory, build descriptor and expected image, run, then compare.
    task automatic run_xfer(int sz, int sinc, int dinc, int n, int arb, int mode,
                            int dsz, bit expect_err, string tag);
        int ss, ds, bytes, slot, exp_y;
        logic [31:0] s_end, d_end, ctl;
        bit ok;
        ss = step_of(sinc);
        ds = step_of(dinc);
        bytes = 1 << (sz > 2 ? 2 : sz);
        s_end = SRC + 32'((n - 1) * ss);
        d_end = DST + 32'((n - 1) * ds);
        for (int a = 0; a < 4096; a++) mem[a] = 8'hEE;
        for (int a = 0; a < 256; a++) mem[SRC + 32'(a)] = 8'((a * 37 + sz * 11 + n) ^ 8'h5A);
        ctl = ctl_word(dinc, dsz, sinc, sz, arb, n, mode);
        put_word(TBL, s_end);
        put_word(TBL + 4, d_end);
        put_word(TBL + 8, ctl);
        for (int a = 0; a < 4096; a++) expm[a] = mem[a];
        if (!expect_err) begin
            // item i (0 first) sits at end - (n-1-i)*step
            for (int i = 0; i < n; i++) begin
                logic [31:0] sa, da;
                sa = s_end - 32'((n - 1 - i) * ss);
                da = d_end - 32'((n - 1 - i) * ds);
                for (int b = 0; b < bytes; b++) expm[da + 32'(b)] = mem[sa + 32'(b)];
            end
            ctl[13:4] = '0;
            ctl[2:0]  = '0;
            for (int b = 0; b < 4; b++) expm[TBL + 32'(b)+8] = ctl[8*b +: 8];
        end
        done_cnt = 0; err_cnt = 0; yield_cnt = 0;
        cmd(3'd0);
        cmd(3'd3);
        cmd(3'd6);
        cmd(3'd4);
        for (int c = 0; c < 30000 && done_cnt == 0 && err_cnt == 0; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        ok = 1'b1;
        for (int a = 32'h0F0; a < 32'h200; a++) if (mem[a] != expm[a]) ok = 1'b0;
        for (int a = 32'h3F0; a < 32'h500; a++) if (mem[a] != expm[a]) ok = 1'b0;
        // R4 R5 R6 R7: descriptor fetch, item count, backward addressing, width
        chk(ok, "R4/R5/R6/R7", {tag, " destination image"}, ok, 1);
        if (expect_err) begin
            // R11
            chk(err_cnt == 1 && done_cnt == 0, "R11", {tag, " error pulses"}, err_cnt, 1);
            chk(get_word(TBL + 8) == ctl_word(dinc, dsz, sinc, sz, arb, n, mode),
                "R11", {tag, " no write-back"}, get_word(TBL + 8),
                ctl_word(dinc, dsz, sinc, sz, arb, n, mode));
        end else begin
            // R9
            chk(get_word(TBL + 8) == ctl, "R9", {tag, " control write-back"},
                get_word(TBL + 8), ctl);
            // R10
            chk(done_cnt == 1 && err_cnt == 0, "R10", {tag, " done pulses"}, done_cnt, 1);
            slot  = (arb >= 10) ? 1024 : (1 << arb);
            exp_y = (n + slot - 1) / slot - 1;
            // R8
            chk(yield_cnt == exp_y, "R8", {tag, " yield count"}, yield_cnt, exp_y);
        end
        chk(ch_en == 1'b0 && busy == 1'b0, "R10", {tag, " enable cleared"}, ch_en, 0);
    endtask

    initial begin
        int n_list [4] = '{1, 2, 8, 9};
        int a_list [3] = '{0, 3, 12};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ch_en == 0 && ch_mask == 1 && ch_burst == 0, "R1", "reset regs",
            {ch_en, ch_mask, ch_burst}, 3'b010);
        chk(busy == 0 && mem_req == 0, "R1", "reset idle", {busy, mem_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 set/clear commands
        cmd(3'd0); chk(ch_en == 1, "R2", "enable set", ch_en, 1);
        cmd(3'd1); chk(ch_en == 0, "R2", "enable clear", ch_en, 0);
        cmd(3'd3); chk(ch_mask == 0, "R2", "mask clear", ch_mask, 0);
        cmd(3'd2); chk(ch_mask == 1, "R2", "mask set", ch_mask, 1);
        cmd(3'd5); chk(ch_burst == 1, "R2", "burst set", ch_burst, 1);
        cmd(3'd6); chk(ch_burst == 0, "R2", "burst clear", ch_burst, 0);

        // R3 dropped requests: disabled, masked, burst-only; none held pending
        busy_cnt = 0;
        cmd(3'd4); repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R3", "request while disabled", busy_cnt, 0);
        cmd(3'd0); cmd(3'd4); repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R3", "request while masked", busy_cnt, 0);
        cmd(3'd5); cmd(3'd3); cmd(3'd4); repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R3", "request while burst-only", busy_cnt, 0);
        cmd(3'd6); repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R3", "no pending start", busy_cnt, 0);
        cmd(3'd1);

        // near-exhaustive sweep: sizes x counts x arbitration codes
        for (int sz = 0; sz < 3; sz++)
            for (int ni = 0; ni < 4; ni++)
                for (int ai = 0; ai < 3; ai++)
                    run_xfer(sz, sz, sz, n_list[ni], a_list[ai], 2, sz, 1'b0,
                             $sformatf("sz%0d n%0d arb%0d", sz, n_list[ni], a_list[ai]));

        // R6 stride wider than item, fixed source, fixed destination
        run_xfer(1, 2, 2, 3, 1, 2, 1, 1'b0, "half stride4");
        run_xfer(2, 3, 2, 4, 2, 2, 2, 1'b0, "fixed source");
        run_xfer(0, 0, 3, 5, 0, 2, 0, 1'b0, "fixed destination");
        // R5 count field extremes within window
        run_xfer(0, 0, 0, 64, 4, 2, 0, 1'b0, "byte n64");

        // R11 bad descriptors
        run_xfer(3, 2, 2, 4, 0, 2, 3, 1'b1, "size3");
        run_xfer(2, 2, 2, 4, 0, 2, 1, 1'b1, "size mismatch");
        run_xfer(2, 2, 2, 4, 0, 1, 2, 1'b1, "mode1");

        report();
    end

endmodule